// File: doc/BRIEF.md
# Bank-Tagged Direct-Mapped Read Cache

This block sits between an 8-bit CPU and a slow shared memory bus, in a system where a bank-switching MMU maps physical banks into fixed windows of the logical address space. Its purpose is to let CPU reads that repeat recently used memory finish in two cycles, instead of waiting for a full bus cycle. A write always goes out on the slow bus. The cache also records the written byte, so a later read of that byte hits.

Each entry is picked directly by the low logical address bits, which are the offset within one MMU window. The entry stores the data byte, the physical bank number the byte came from, and a valid bit. It stores no address bits. A lookup hits when the entry is valid and its stored bank equals the bank that the MMU currently maps at the CPU's address. Two logical windows that map the same bank therefore share entries, which is correct, because they are the same physical byte. Accesses to the hardware-register page (upper address byte 0xFF) always bypass the cache.

After reset the block walks through every entry and clears it. The CPU side uses a one-cycle request, accepted only while `ready_o` is high, and sees a one-cycle `done_o` pulse when the access completes. The bus side holds its request until the bus acknowledges it.

Top module: `bank_read_cache`

## Requirements
- R1: After reset, `ready_o` stays low for at least 2^IDX_W cycles while every entry is written invalid. After that, the first read of any address misses.
- R2: A read hits when the entry at index `addr_i[IDX_W-1:0]` is valid and its stored bank equals `bank_i`. It then completes with `done_o`=1, `hit_o`=1 and the stored byte, two cycles after acceptance, with no bus request.
- R3: A cacheable read that misses raises `bus_req_o` with `bus_we_o`=0, carrying the accepted address and bank. On the cycle after `bus_ack_i` it completes with `hit_o`=0 and the returned byte, and that byte is written into the entry together with the current bank.
- R4: The index is `addr_i[IDX_W-1:0]` only. A read in another window (different upper address bits) that carries the same bank hits on the byte filled through the first window.
- R5: An entry whose stored bank differs from `bank_i` misses, and the fill that follows replaces both its byte and its bank.
- R6: Every write raises `bus_req_o` with `bus_we_o`=1, carrying the accepted address, bank and data, whether or not the entry is present. A write completes after `bus_ack_i` with `hit_o`=0.
- R7: A write outside the register page sets the entry to valid, with the written byte and the current bank, so a following read with that bank hits and returns the written byte.
- R8: When `addr_i[15:8]` is 0xFF, a read always goes to the bus and never reports a hit. Neither a read nor a write in that page changes the entry that shares its index.
- R9: While `bus_req_o` is high and `bus_ack_i` is low, `bus_req_o`, `bus_we_o`, `bus_addr_o`, `bus_bank_o` and `bus_wdata_o` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request, one cycle, only while ready_o is high |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | ADDR_W | CPU logical address |
| bank_i | input | BANK_W | Bank currently mapped at addr_i |
| wdata_i | input | DATA_W | CPU write data |
| ready_o | output | 1 | Block idle and able to accept a request |
| done_o | output | 1 | Access complete (one cycle) |
| hit_o | output | 1 | Completed read was served from the cache (valid with done_o) |
| rdata_o | output | DATA_W | Read data (valid with done_o) |
| bus_req_o | output | 1 | Slow bus cycle request |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_addr_o | output | ADDR_W | Logical address of the bus cycle |
| bus_bank_o | output | BANK_W | Bank of the bus cycle |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_ack_i | input | 1 | Bus cycle complete (one cycle) |
| bus_rdata_i | input | DATA_W | Bus read data, valid with bus_ack_i |

## Verification
The bench reads the same offset through two windows that map the same bank, and expects a hit. A design that stored or compared upper address bits would miss there, and one that ignored the bank would hit wrongly after a remap. It fills an entry, then reads and writes the register page at the address that aliases that entry. A design without the page exclusion would return a stale byte for a volatile register, or would corrupt the aliased byte. It writes to an entry with a different bank and then reads with both banks, which catches a write-through that updates only the data and not the tag. It also checks that writes reach the bus even when the entry hits, and it holds off the bus acknowledge for several cycles to catch a request that drifts while it waits.

// File: rtl/rcache_pkg.sv
package rcache_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_BRD,
    ST_BWR,
    ST_RESP
  } rc_state_e;
endpackage

// File: rtl/rcache_walker.sv
// Clears every entry once after reset, one index per cycle.
module rcache_walker #(
  parameter int IDX_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = cnt_q;
endmodule

// File: rtl/rcache_store.sv
// Entry array: synchronous read, one write port.
module rcache_store #(
  parameter int IDX_W = 13,
  parameter int ENT_W = 17
) (
  input  logic             clk_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_ent_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ENT_W-1:0] wr_ent_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_ent_i;
    if (rd_en_i) rd_q <= mem_q[rd_idx_i];
  end

  assign rd_ent_o = rd_q;
endmodule

// File: rtl/rcache_tagcmp.sv
// Entry layout: {valid, bank, data}.
module rcache_tagcmp #(
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [BANK_W+DATA_W:0] ent_i,
  input  logic [BANK_W-1:0]      bank_i,
  output logic                   hit_o,
  output logic [DATA_W-1:0]      data_o
);
  assign hit_o  = ent_i[BANK_W+DATA_W] && (ent_i[DATA_W +: BANK_W] == bank_i);
  assign data_o = ent_i[DATA_W-1:0];
endmodule

// File: rtl/rcache_ctrl.sv
module rcache_ctrl
  import rcache_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         IDX_W   = 13,
  parameter int         BANK_W  = 8,
  parameter int         DATA_W  = 8,
  parameter bit         IO_EXCL = 1'b1,
  parameter logic [7:0] IO_PAGE = 8'hFF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_busy_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic                   ready_o,
  output logic                   done_o,
  output logic                   hit_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rd_en_o,
  output logic [IDX_W-1:0]       rd_idx_o,
  output logic [BANK_W-1:0]      cmp_bank_o,
  input  logic                   lk_hit_i,
  input  logic [DATA_W-1:0]      lk_data_i,
  output logic                   fill_en_o,
  output logic [IDX_W-1:0]       fill_idx_o,
  output logic [BANK_W+DATA_W:0] fill_ent_o,
  output logic                   bus_req_o,
  output logic                   bus_we_o,
  output logic [ADDR_W-1:0]      bus_addr_o,
  output logic [BANK_W-1:0]      bus_bank_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  input  logic                   bus_ack_i,
  input  logic [DATA_W-1:0]      bus_rdata_i
);
  rc_state_e st_q, st_d;

  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, io_q, hit_q;
  logic              acc_io, accept, bus_done;

  generate
    if (IO_EXCL) begin : g_io
      assign acc_io = (addr_i[ADDR_W-1 -: 8] == IO_PAGE);
    end else begin : g_no_io
      assign acc_io = 1'b0;
    end
  endgenerate

  assign accept   = (st_q == ST_IDLE) && req_i;
  assign bus_done = ((st_q == ST_BRD) || (st_q == ST_BWR)) && bus_ack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_INIT: if (!init_busy_i) st_d = ST_IDLE;
      ST_IDLE: if (req_i) st_d = we_i ? ST_BWR : (acc_io ? ST_BRD : ST_LOOK);
      ST_LOOK: st_d = lk_hit_i ? ST_RESP : ST_BRD;
      ST_BRD,
      ST_BWR:  if (bus_ack_i) st_d = ST_RESP;
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INIT;
      addr_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      io_q    <= 1'b0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= addr_i;
        bank_q  <= bank_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
        io_q    <= acc_io;
      end
      if (st_q == ST_LOOK && lk_hit_i) begin
        rdata_q <= lk_data_i;
        hit_q   <= 1'b1;
      end
      if (bus_done) begin
        rdata_q <= we_q ? wdata_q : bus_rdata_i;
        hit_q   <= 1'b0;
      end
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign done_o     = (st_q == ST_RESP);
  assign hit_o      = hit_q;
  assign rdata_o    = rdata_q;
  assign rd_en_o    = accept;
  assign rd_idx_o   = addr_i[IDX_W-1:0];
  assign cmp_bank_o = bank_q;

  // Fill on read miss and write-through; register page never allocates.
  assign fill_en_o  = bus_done && !io_q;
  assign fill_idx_o = addr_q[IDX_W-1:0];
  assign fill_ent_o = {1'b1, bank_q, (we_q ? wdata_q : bus_rdata_i)};

  assign bus_req_o   = (st_q == ST_BRD) || (st_q == ST_BWR);
  assign bus_we_o    = (st_q == ST_BWR);
  assign bus_addr_o  = addr_q;
  assign bus_bank_o  = bank_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/bank_read_cache.sv
module bank_read_cache #(
  parameter int         ADDR_W  = 16,
  parameter int         IDX_W   = 13,
  parameter int         BANK_W  = 8,
  parameter int         DATA_W  = 8,
  parameter bit         IO_EXCL = 1'b1,
  parameter logic [7:0] IO_PAGE = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BANK_W-1:0] bus_bank_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int ENT_W = 1 + BANK_W + DATA_W;

  logic             walk_busy;
  logic [IDX_W-1:0] walk_idx;
  logic             rd_en, fill_en, lk_hit;
  logic [IDX_W-1:0] rd_idx, fill_idx, wr_idx;
  logic [ENT_W-1:0] rd_ent, fill_ent, wr_ent;
  logic [BANK_W-1:0] cmp_bank;
  logic [DATA_W-1:0] lk_data;
  logic             wr_en;

  rcache_walker #(.IDX_W(IDX_W)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (walk_busy),
    .idx_o  (walk_idx)
  );

  assign wr_en  = walk_busy || fill_en;
  assign wr_idx = walk_busy ? walk_idx : fill_idx;
  assign wr_ent = walk_busy ? '0 : fill_ent;

  rcache_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk_i    (clk_i),
    .rd_en_i  (rd_en),
    .rd_idx_i (rd_idx),
    .rd_ent_o (rd_ent),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_ent_i (wr_ent)
  );

  rcache_tagcmp #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_cmp (
    .ent_i  (rd_ent),
    .bank_i (cmp_bank),
    .hit_o  (lk_hit),
    .data_o (lk_data)
  );

  rcache_ctrl #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W),
    .IO_EXCL(IO_EXCL),
    .IO_PAGE(IO_PAGE)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_busy_i (walk_busy),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .bank_i      (bank_i),
    .wdata_i     (wdata_i),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .hit_o       (hit_o),
    .rdata_o     (rdata_o),
    .rd_en_o     (rd_en),
    .rd_idx_o    (rd_idx),
    .cmp_bank_o  (cmp_bank),
    .lk_hit_i    (lk_hit),
    .lk_data_i   (lk_data),
    .fill_en_o   (fill_en),
    .fill_idx_o  (fill_idx),
    .fill_ent_o  (fill_ent),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_bank_o  (bus_bank_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i)
  );
endmodule

// File: rtl/bank_read_cache_chk.sv
module bank_read_cache_chk #(
  parameter int         ADDR_W  = 16,
  parameter int         BANK_W  = 8,
  parameter int         DATA_W  = 8,
  parameter bit         IO_EXCL = 1'b1,
  parameter logic [7:0] IO_PAGE = 8'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              hit_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [BANK_W-1:0] bus_bank_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  logic acc_we_q, acc_io_q, bus_seen_q;
  logic accept;

  assign accept = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_we_q   <= 1'b0;
      acc_io_q   <= 1'b0;
      bus_seen_q <= 1'b0;
    end else if (accept) begin
      acc_we_q   <= we_i;
      acc_io_q   <= IO_EXCL && (addr_i[ADDR_W-1 -: 8] == IO_PAGE);
      bus_seen_q <= 1'b0;
    end else if (bus_req_o) begin
      bus_seen_q <= 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !bus_req_o && !done_o);

  assert_hit_nobus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && hit_o |-> !bus_seen_q);

  assert_ack_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> done_o);

  assert_write_nohit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && acc_we_q |-> !hit_o);

  assert_iopage_nohit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && acc_io_q |-> !hit_o);

  assert_bus_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)
      && $stable(bus_bank_o) && $stable(bus_wdata_o));
endmodule

bind bank_read_cache bank_read_cache_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .DATA_W (DATA_W),
  .IO_EXCL(IO_EXCL),
  .IO_PAGE(IO_PAGE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .hit_o       (hit_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_bank_o  (bus_bank_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/bank_read_cache_test.sv
`timescale 1ns/1ps
module bank_read_cache_test;
  localparam int DEPTH = 1 << 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  bank_i = '0, wdata_i = '0;
  logic        ready_o, done_o, hit_o;
  logic [7:0]  rdata_o;
  logic        bus_req_o, bus_we_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_bank_o, bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [7:0]  bus_rdata_i = '0;

  bank_read_cache uut (.*);

  always #4 clk_i = ~clk_i;

  int nvec = 0, nerr = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- memory / bus model ----
  logic [7:0] mem [int];
  int   n_rd = 0, n_wr = 0, ack_delay = 0, wait_n = 0;
  bit   pend = 0;
  logic [7:0] io_cnt = 8'h11;
  logic [15:0] h_addr; logic [7:0] h_bank, h_wdata; logic h_we;
  logic [15:0] l_addr; logic [7:0] l_bank, l_wdata; logic l_we;

  function automatic int key(input logic [7:0] b, input logic [15:0] a);
    return int'({11'd0, b, a[12:0]});
  endfunction

  function automatic logic [7:0] model(input logic [7:0] b, input logic [15:0] a);
    if (mem.exists(key(b, a))) return mem[key(b, a)];
    return (a[7:0] ^ {a[12:8], 3'b101}) + b * 8'd3;
  endfunction

  always @(negedge clk_i) begin
    if (bus_ack_i) bus_ack_i = 1'b0;
    else if (bus_req_o) begin
      if (!pend) begin
        pend = 1; wait_n = 0;
        h_addr = bus_addr_o; h_bank = bus_bank_o; h_we = bus_we_o; h_wdata = bus_wdata_o;
      end else begin
        chk("R9 bus addr hold", bus_addr_o, h_addr);
        chk("R9 bus ctl hold", {bus_we_o, bus_bank_o, bus_wdata_o}, {h_we, h_bank, h_wdata});
      end
      if (wait_n >= ack_delay) begin
        l_addr = bus_addr_o; l_bank = bus_bank_o; l_we = bus_we_o; l_wdata = bus_wdata_o;
        if (bus_addr_o[15:8] == 8'hFF) begin
          if (!bus_we_o) begin bus_rdata_i = io_cnt; io_cnt = io_cnt + 8'd7; end
        end else if (bus_we_o) mem[key(bus_bank_o, bus_addr_o)] = bus_wdata_o;
        else bus_rdata_i = model(bus_bank_o, bus_addr_o);
        if (bus_we_o) n_wr++; else n_rd++;
        bus_ack_i = 1'b1; pend = 0;
      end else wait_n++;
    end
  end

  // ---- CPU access ----
  task automatic cpu(input logic we, input logic [15:0] a, input logic [7:0] b,
                     input logic [7:0] wd, output logic [7:0] rd, output logic h, output int lat);
    @(negedge clk_i);
    req_i = 1; we_i = we; addr_i = a; bank_i = b; wdata_i = wd;
    @(negedge clk_i);
    req_i = 0;
    lat = 1;
    while (!done_o && lat < 100) begin @(negedge clk_i); lat++; end
    rd = rdata_o; h = hit_o;
  endtask

  logic [7:0] rd; logic h; int lat, base;

  task automatic t_reset();
    int cyc = 0;
    repeat (100) @(negedge clk_i);
    chk("R1 ready low during walk", ready_o, 0);
    cyc = 100;
    while (!ready_o && cyc < DEPTH + 50) begin @(negedge clk_i); cyc++; end
    chk("R1 ready after walk", ready_o, 1);
    chk("R1 walk length", int'(cyc >= DEPTH), 1);
    base = n_rd;
    cpu(0, 16'h0123, 8'd7, 0, rd, h, lat);
    chk("R1 first read misses", h, 0);
    chk("R1 first read bus", n_rd - base, 1);
  endtask

  task automatic t_miss_fill();
    base = n_rd;
    cpu(0, 16'h0456, 8'd2, 0, rd, h, lat);
    chk("R3 miss hit flag", h, 0);
    chk("R3 miss data", rd, model(8'd2, 16'h0456));
    chk("R3 bus addr", l_addr, 16'h0456);
    chk("R3 bus bank/we", {l_bank, l_we}, {8'd2, 1'b0});
    cpu(0, 16'h0456, 8'd2, 0, rd, h, lat);
    chk("R2 hit flag", h, 1);
    chk("R2 hit data", rd, model(8'd2, 16'h0456));
    chk("R2 hit latency", lat, 2);
    chk("R2 no bus on hit", n_rd - base, 1);
  endtask

  task automatic t_alias();
    cpu(0, 16'h0020, 8'd3, 0, rd, h, lat);
    chk("R4 first window miss", h, 0);
    cpu(0, 16'h2020, 8'd3, 0, rd, h, lat);
    chk("R4 other window same bank hits", h, 1);
    chk("R4 alias data", rd, model(8'd3, 16'h0020));
    cpu(0, 16'h4020, 8'd9, 0, rd, h, lat);
    chk("R5 bank mismatch misses", h, 0);
    chk("R5 refill data", rd, model(8'd9, 16'h4020));
    cpu(0, 16'h0020, 8'd3, 0, rd, h, lat);
    chk("R5 evicted bank misses", h, 0);
  endtask

  task automatic t_write();
    base = n_wr;
    cpu(1, 16'h0300, 8'd4, 8'hA5, rd, h, lat);
    chk("R6 write no hit", h, 0);
    chk("R6 bus write", {l_we, l_bank, l_wdata}, {1'b1, 8'd4, 8'hA5});
    chk("R6 bus write addr", l_addr, 16'h0300);
    base = n_rd;
    cpu(0, 16'h0300, 8'd4, 0, rd, h, lat);
    chk("R7 read after write hits", h, 1);
    chk("R7 written data", rd, 8'hA5);
    chk("R7 no bus read", n_rd - base, 0);
    base = n_wr;
    cpu(1, 16'h0300, 8'd4, 8'h5A, rd, h, lat);
    chk("R6 write on present entry goes out", n_wr - base, 1);
    chk("R6 write on present entry no hit", h, 0);
  endtask

  task automatic t_retag();
    cpu(1, 16'h0300, 8'd6, 8'h3C, rd, h, lat);
    cpu(0, 16'h0300, 8'd6, 0, rd, h, lat);
    chk("R7 retagged hit", h, 1);
    chk("R7 retagged data", rd, 8'h3C);
    cpu(0, 16'h0300, 8'd4, 0, rd, h, lat);
    chk("R5 old bank misses after retag", h, 0);
    chk("R5 old bank data from memory", rd, 8'h5A);
  endtask

  task automatic t_io();
    logic [7:0] keep;
    cpu(0, 16'h1F10, 8'd5, 0, rd, h, lat);
    keep = model(8'd5, 16'h1F10);
    cpu(0, 16'h1F10, 8'd5, 0, rd, h, lat);
    chk("R8 aliased entry filled", h, 1);
    base = n_rd;
    cpu(0, 16'hFF10, 8'd5, 0, rd, h, lat);
    chk("R8 register read no hit", h, 0);
    chk("R8 register read data", rd, 8'h11);
    cpu(0, 16'hFF10, 8'd5, 0, rd, h, lat);
    chk("R8 register reread data", rd, 8'h18);
    chk("R8 register reads on bus", n_rd - base, 2);
    cpu(1, 16'hFF10, 8'd5, 8'h77, rd, h, lat);
    cpu(0, 16'h1F10, 8'd5, 0, rd, h, lat);
    chk("R8 aliased entry untouched hit", h, 1);
    chk("R8 aliased entry untouched data", rd, keep);
  endtask

  task automatic t_hold();
    ack_delay = 4;
    cpu(0, 16'h0777, 8'd1, 0, rd, h, lat);
    chk("R9 delayed miss data", rd, model(8'd1, 16'h0777));
    chk("R9 delayed miss latency", int'(lat >= 7), 1);
    cpu(1, 16'h0778, 8'd1, 8'hC3, rd, h, lat);
    chk("R9 delayed write data", l_wdata, 8'hC3);
    ack_delay = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_miss_fill();
    t_alias();
    t_write();
    t_retag();
    t_io();
    t_hold();
    repeat (4) @(negedge clk_i);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog R1-path actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule